// File: doc/BRIEF.md
# Keyboard Matrix and Cassette Input Port

This block is a read-only input port on an 8-bit CPU bus. It scans a keyboard matrix of 12 row lines and 7 column lines and also samples a cassette input level. Software reads a byte from a 2 KiB window. The low address bits of that read pick which keyboard rows are pulled low. The port returns the column levels together with the cassette bit. A column that reads 0 means that a key on a selected row at that column is pressed.

Rows 0 to 7 follow the address bits one for one, with active-low selection. Rows 8 to 11 come from a 3-bit binary field that feeds a small decoder, and four of its codes select no row. The rows are driven combinationally while the read is on the bus, so the columns settle within that cycle. The returned byte is registered at the clock edge that ends the read, and a qualifying enable marks the cycle in which it is valid.

Top module: `kbd_cassette_port`

## Requirements
- R1: A read is decoded only when `bus_rd` is 1, `io_bank_sel` is 1 and `bus_addr[15:11]` equals 5'b01101, which is the window 0x6800 to 0x6FFF. Any other address, or a deasserted bank select or read strobe, produces no response.
- R2: During a decoded read, `row_n[i]` for i in 0..7 is low exactly when `bus_addr[i]` is 0. For example, offset 0x7FE selects only row 0 and offset 0x77F selects only row 7.
- R3: During a decoded read, the value v of `bus_addr[10:8]` pulls `row_n[8+v]` low for v = 0 to 3. The values 4 to 7 pull none of `row_n[11:8]` low, and at most one of those four rows is ever low.
- R4: Outside a decoded read, all 12 `row_n` lines stay high.
- R5: On the clock edge that ends a decoded read, the port captures the column inputs into `rd_data[6:0]` (column c on bit c) and the cassette level into `rd_data[7]`. The captured byte holds for the following cycle.
- R6: `rd_data_oe` is 1 in the cycle after a decoded read and 0 otherwise. While it is 0, `rd_data` reads 0x00.
- R7: When several rows are low together, the returned columns are the AND of what each selected row alone would give. A column reads 0 if any selected row has its key at that column pressed.
- R8: After reset, `rd_data_oe` is 0, `rd_data` is 0x00 and every row line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | Read strobe, active high |
| io_bank_sel | input | 1 | High when the I/O bank is paged into the slot |
| row_n | output | 12 | Keyboard row drives, active low |
| col_n | input | 7 | Keyboard column levels, 0 = pressed |
| tape_in | input | 1 | Cassette input level |
| rd_data | output | 8 | Returned byte: tape level in bit 7, columns in bits 6..0 |
| rd_data_oe | output | 1 | Enable for the returned byte |

## Verification
The bench probes both edges of the window, 0x67FE and 0x7000, and also a read with the bank deselected. A window compare that is off by one bit would answer one of these reads, and it would pull rows or raise the enable. The bench walks every extended code, including the four codes that must select no row. A decoder that wraps code 4 back onto row 8, or that ignores the field, would give the wrong column byte. The bench also opens a direct row and an extended row at the same time to confirm that the column results combine with AND. It checks that the cassette bit lands in bit 7 and not in the column field.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int KBD_DIRECT_ROWS = 8;
    localparam int KBD_EXT_ROWS    = 4;
    localparam int KBD_EXT_SEL_W   = 3;
    localparam int KBD_COLS        = 7;
    localparam int KBD_ADDR_W      = 16;
    localparam int KBD_DATA_W      = KBD_COLS + 1;

    typedef struct packed {
        logic [KBD_DATA_W-1:0] data;
        logic                  oe;
    } kbd_port_state_t;
endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode #(
    parameter int              ADDR_W   = 16,
    parameter int              WIN_LSB  = 11,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6800
) (
    input  logic [ADDR_W-1:WIN_LSB] addr_hi,
    input  logic                    rd,
    input  logic                    bank_sel,
    output logic                    hit
);
    always_comb begin
        hit = rd && bank_sel && (addr_hi == WIN_BASE[ADDR_W-1:WIN_LSB]);
    end
endmodule

// File: rtl/kbd_row_decode.sv
module kbd_row_decode #(
    parameter int DIRECT_ROWS = 8,
    parameter int EXT_ROWS    = 4,
    parameter int EXT_SEL_W   = 3,
    localparam int SEL_W      = DIRECT_ROWS + EXT_SEL_W,
    localparam int ROWS       = DIRECT_ROWS + EXT_ROWS
) (
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic [ROWS-1:0]  row_n
);
    logic [EXT_SEL_W-1:0] ext_code;
    assign ext_code = sel[DIRECT_ROWS +: EXT_SEL_W];

    for (genvar i = 0; i < DIRECT_ROWS; i++) begin : g_direct
        assign row_n[i] = ~(active & ~sel[i]);
    end

    for (genvar j = 0; j < EXT_ROWS; j++) begin : g_ext
        assign row_n[DIRECT_ROWS + j] = ~(active & (ext_code == EXT_SEL_W'(j)));
    end
endmodule

// File: rtl/kbd_cassette_port.sv
module kbd_cassette_port
    import kbd_pkg::*;
#(
    parameter int                ADDR_W      = KBD_ADDR_W,
    parameter int                DIRECT_ROWS = KBD_DIRECT_ROWS,
    parameter int                EXT_ROWS    = KBD_EXT_ROWS,
    parameter int                EXT_SEL_W   = KBD_EXT_SEL_W,
    parameter int                COLS        = KBD_COLS,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 16'h6800,
    localparam int               WIN_LSB     = DIRECT_ROWS + EXT_SEL_W,
    localparam int               ROWS        = DIRECT_ROWS + EXT_ROWS,
    localparam int               DATA_W      = COLS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              io_bank_sel,
    output logic [ROWS-1:0]   row_n,
    input  logic [COLS-1:0]   col_n,
    input  logic              tape_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_oe
);
    logic            hit;
    kbd_port_state_t state_d, state_q;

    kbd_addr_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_LSB (WIN_LSB),
        .WIN_BASE(WIN_BASE)
    ) u_addr_decode (
        .addr_hi (bus_addr[ADDR_W-1:WIN_LSB]),
        .rd      (bus_rd),
        .bank_sel(io_bank_sel),
        .hit     (hit)
    );

    kbd_row_decode #(
        .DIRECT_ROWS(DIRECT_ROWS),
        .EXT_ROWS   (EXT_ROWS),
        .EXT_SEL_W  (EXT_SEL_W)
    ) u_row_decode (
        .active(hit),
        .sel   (bus_addr[WIN_LSB-1:0]),
        .row_n (row_n)
    );

    always_comb begin
        state_d      = '0;
        if (hit) begin
            state_d.data = {tape_in, col_n};
            state_d.oe   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data    = state_q.data;
    assign rd_data_oe = state_q.oe;
endmodule

// File: rtl/kbd_cassette_port_chk.sv
module kbd_cassette_port_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6800
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              io_bank_sel,
    input logic [11:0]       row_n,
    input logic [6:0]        col_n,
    input logic              tape_in,
    input logic [7:0]        rd_data,
    input logic              rd_data_oe
);
    logic req_hit;
    assign req_hit = bus_rd && io_bank_sel && (bus_addr[ADDR_W-1:11] == WIN_BASE[ADDR_W-1:11]);

    assert_rows_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_hit |-> (&row_n));

    assert_direct_rows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |-> (row_n[7:0] == bus_addr[7:0]));

    assert_ext_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~row_n[11:8]));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |=> (rd_data == {$past(tape_in), $past(col_n)}));

    assert_oe_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |=> rd_data_oe);

    assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_hit |=> !rd_data_oe);

    assert_data_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_oe |-> (rd_data == 8'h00));

    assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !io_bank_sel |-> (&row_n));
endmodule

bind kbd_cassette_port kbd_cassette_port_chk #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .io_bank_sel(io_bank_sel),
    .row_n      (row_n),
    .col_n      (col_n),
    .tape_in    (tape_in),
    .rd_data    (rd_data),
    .rd_data_oe (rd_data_oe)
);

// File: tb/kbd_cassette_port_bench.sv
module kbd_cassette_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rd = 1'b0;
    logic        io_bank_sel = 1'b0;
    logic [11:0] row_n;
    logic [6:0]  col_n;
    logic        tape_in = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_data_oe;

    logic [6:0]  keys [12];
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    kbd_cassette_port u_kbd_cassette_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .io_bank_sel(io_bank_sel),
        .row_n      (row_n),
        .col_n      (col_n),
        .tape_in    (tape_in),
        .rd_data    (rd_data),
        .rd_data_oe (rd_data_oe)
    );

    // Matrix model: a low row pulls every column with a pressed key low.
    always_comb begin
        col_n = 7'h7F;
        for (int r = 0; r < 12; r++) begin
            if (!row_n[r]) col_n = col_n & ~keys[r];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_rows(input logic [15:0] a, input bit bank, input bit rd);
        logic [11:0] r;
        r = 12'hFFF;
        if (rd && bank && a[15:11] == 5'b01101) begin
            for (int i = 0; i < 8; i++) r[i] = a[i];
            for (int j = 0; j < 4; j++) r[8+j] = (a[10:8] != 3'(j));
        end
        return r;
    endfunction

    function automatic logic [6:0] exp_cols(input logic [11:0] rows);
        logic [6:0] c;
        c = 7'h7F;
        for (int r = 0; r < 12; r++) if (!rows[r]) c = c & ~keys[r];
        return c;
    endfunction

    task automatic clear_keys();
        for (int r = 0; r < 12; r++) keys[r] = 7'h00;
    endtask

    task automatic do_read(input logic [15:0] a, input bit bank, input bit rd, input string req);
        logic [11:0] er;
        bit          hit;
        logic [7:0]  ed;
        @(negedge clk);
        bus_addr = a; io_bank_sel = bank; bus_rd = rd;
        er  = exp_rows(a, bank, rd);
        hit = rd && bank && a[15:11] == 5'b01101;
        ed  = hit ? {tape_in, exp_cols(er)} : 8'h00;
        #1;
        chk(row_n == er, {req, " rows"}, 32'(row_n), 32'(er));
        @(negedge clk);
        bus_rd = 1'b0; io_bank_sel = 1'b0;
        chk(rd_data_oe == hit, {req, " oe"}, 32'(rd_data_oe), 32'(hit));
        chk(rd_data == ed, {req, " data"}, 32'(rd_data), 32'(ed));
    endtask

    task automatic t_reset();
        #1;
        chk(rd_data_oe == 1'b0, "R8 oe", 32'(rd_data_oe), 0);
        chk(rd_data == 8'h00, "R8 data", 32'(rd_data), 0);
        chk(row_n == 12'hFFF, "R8 rows", 32'(row_n), 32'hFFF);
    endtask

    task automatic t_direct_rows();
        clear_keys();
        for (int i = 0; i < 8; i++) keys[i] = 7'(1 << (i % 7));
        for (int i = 0; i < 8; i++) do_read(16'h6800 | (16'h07FF & ~(16'd1 << i)), 1'b1, 1'b1, "R2/R5 direct");
        do_read(16'h6F7F, 1'b1, 1'b1, "R2 row7 high alias");
    endtask

    task automatic t_ext_rows();
        clear_keys();
        keys[8] = 7'h01; keys[9] = 7'h08; keys[10] = 7'h20; keys[11] = 7'h40;
        for (int v = 0; v < 8; v++) do_read(16'h6800 | (16'(v) << 8) | 16'h00FF, 1'b1, 1'b1, "R3 ext code");
    endtask

    task automatic t_outside();
        clear_keys();
        keys[0] = 7'h7F;
        do_read(16'h67FE, 1'b1, 1'b1, "R1 below window");
        do_read(16'h7000, 1'b1, 1'b1, "R1 above window");
        do_read(16'h6FFE, 1'b0, 1'b1, "R1 bank off");
        do_read(16'h6FFE, 1'b1, 1'b0, "R4 no strobe");
        @(negedge clk);
        chk(row_n == 12'hFFF, "R4 idle rows", 32'(row_n), 32'hFFF);
        chk(rd_data == 8'h00, "R6 idle data", 32'(rd_data), 0);
    endtask

    task automatic t_wired_and();
        clear_keys();
        keys[0] = 7'h04; keys[1] = 7'h20; keys[8] = 7'h01;
        do_read(16'h6FFC, 1'b1, 1'b1, "R7 rows 0+1");
        do_read(16'h68FE, 1'b1, 1'b1, "R7 rows 0+8");
        do_read(16'h6800, 1'b1, 1'b1, "R7 all direct + row8");
    endtask

    task automatic t_tape();
        clear_keys();
        keys[3] = 7'h10;
        tape_in = 1'b1;
        do_read(16'h6FF7, 1'b1, 1'b1, "R5 tape high");
        tape_in = 1'b0;
        do_read(16'h6FF7, 1'b1, 1'b1, "R5 tape low");
        tape_in = 1'b1;
        do_read(16'h6FFF, 1'b1, 1'b1, "R5 tape no row");
        tape_in = 1'b0;
    endtask

    initial begin
        clear_keys();
        #12;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_direct_rows();
        t_ext_rows();
        t_outside();
        t_wired_and();
        t_tape();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule